// File: doc/BRIEF.md
# Segmented DRAM Row Cache Controller

This controller runs in a memory controller. It treats the short, fast segment of every DRAM subarray as an inclusive cache for rows held in the long, slow segment of that subarray. Each subarray has 512 rows. The 32 rows nearest the sense amplifiers form the fast segment, and the other 480 rows form the backing store. A cached row also keeps its copy in the slow segment.

Each accepted request names a bank, a subarray, a slow-row index, a direction, and a flag from the scheduler that says whether the request waited behind a different row in the same subarray. The controller looks up the tag set of that subarray and decides between a hit, a plain miss and an insertion. It then issues a closed-row command sequence: activate, access, precharge. An insertion copies a row by activating the source row and then the destination row on the shared bitlines. A fixed number of extra cycles follows the second activate. A dirty victim is first copied back to its home row in the same way. Three policies select which rows get inserted and which row is replaced.

Top module: `segrow_cache_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_valid` and `resp_valid` are 0, and every tag entry is empty, so the first request to any row misses.
- R2: A request whose index matches a valid entry of its own bank and subarray is a hit. The controller issues ACT on fast row s with `cmd_fast`=1, then the access, then PRE. The response comes 3 cycles after acceptance with `resp_hit`=1 and `resp_fast`=1. Tags of different subarrays are independent.
- R3: A miss that is not inserted issues ACT on row 32+k, where k is the slow index, then the access, then PRE. The response comes 3 cycles after acceptance with hit, fast and fill all 0.
- R4: An inserted miss issues ACT on slow row 32+k, ACT on fast row s, MIG_EXTRA idle cycles, the access, then PRE. The response comes 4+MIG_EXTRA cycles after acceptance with `resp_fill`=1, and the next request to the same row hits slot s. Empty slots are filled lowest index first.
- R5: With `cfg_mode` 0 or 3, every miss is inserted. When the set is full, the least recently used slot is the victim.
- R6: With `cfg_mode` 1, a miss is inserted only if `req_waited`=1.
- R7: With `cfg_mode` 2, every miss is inserted. A new entry's counter starts at 1+waited, and each hit adds 1+waited. The victim of a full set is the slot with the lowest counter, and on a tie the lowest index wins.
- R8: A counter saturates at 255. When a hit brings a counter to 255, every counter in that subarray is halved, rounding down.
- R9: A write hit marks the entry dirty. An entry filled by a write miss, or only read, stays clean.
- R10: Evicting a dirty victim first issues ACT on fast row s, ACT on its slow home row, MIG_EXTRA idle cycles and PRE. The insertion follows. The response has `resp_writeback`=1 and comes 7+2*MIG_EXTRA cycles after acceptance.
- R11: `req_ready` is 0 from the acceptance edge through the response cycle and is 1 in the cycle after it. Commands use the codes ACT=1, RD=2, WR=3, PRE=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Policy: 0/3 LRU-all, 1 wait-only, 2 benefit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_bank | input | 1 | Bank number |
| req_sub | input | 1 | Subarray number within the bank |
| req_row | input | 9 | Slow-segment row index (0..479) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_waited | input | 1 | Request waited behind another row in the subarray |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 3 | Command code |
| cmd_bank | output | 1 | Command bank |
| cmd_sub | output | 1 | Command subarray |
| cmd_row | output | 9 | Physical row: fast s → s, slow k → 32+k |
| cmd_fast | output | 1 | Command uses fast-segment timing |
| resp_valid | output | 1 | Request completes this cycle |
| resp_hit | output | 1 | Request hit the fast segment |
| resp_fast | output | 1 | Request was served with fast timing |
| resp_fill | output | 1 | Row was inserted |
| resp_writeback | output | 1 | A dirty victim was copied back |

## Verification
A corrupted tag entry shows up at the ports on the next request to the affected row or slot. A wrong hit or miss appears at the response three cycles later, and a wrong destination slot appears on the first activate of the next hit. Bad recency or counter state stays hidden until a full set has to pick a victim. The bench therefore fills whole subarrays and arranges the counter values so that a missing halving step, or a wrong tie rule, evicts a different row. That row's next request then misses or hits unexpectedly. A lost dirty bit shows as `resp_writeback`=0 and a response that arrives 3+MIG_EXTRA cycles early.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int ROWS_PER_SUB = 512;
    localparam int FAST_ROWS    = 32;
    localparam int SLOW_ROWS    = ROWS_PER_SUB - FAST_ROWS;
    localparam int ROW_W        = $clog2(ROWS_PER_SUB);
    localparam int SLOT_W       = $clog2(FAST_ROWS);
    localparam int TAG_W        = $clog2(SLOW_ROWS);
    localparam int BEN_W        = 8;
    localparam logic [BEN_W-1:0] BEN_MAX = '1;

    typedef enum logic [1:0] {
        POL_SIMPLE  = 2'd0,
        POL_WAITMIN = 2'd1,
        POL_BENEFIT = 2'd2,
        POL_ALT     = 2'd3
    } policy_e;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [SLOT_W-1:0] rank;
        logic [BEN_W-1:0]  benefit;
    } tag_entry_t;

    typedef struct packed {
        logic              hit;
        logic              fill;
        logic              wb;
        logic              wr;
        logic [SLOT_W-1:0] slot;
        logic [TAG_W-1:0]  old_tag;
        logic [TAG_W-1:0]  new_tag;
    } plan_t;

    function automatic logic [ROW_W-1:0] slow_row(input logic [TAG_W-1:0] idx);
        return ROW_W'(FAST_ROWS) + ROW_W'(idx);
    endfunction

    function automatic logic [ROW_W-1:0] fast_row(input logic [SLOT_W-1:0] s);
        return ROW_W'(s);
    endfunction
endpackage

// File: rtl/rc_set_lookup.sv
module rc_set_lookup import rc_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  tag_entry_t        set_i [FAST_ROWS],
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              use_benefit_i,
    output logic              hit_o,
    output logic [SLOT_W-1:0] hit_slot_o,
    output logic [SLOT_W-1:0] victim_o
);
    logic [FAST_ROWS-1:0] match;
    logic                 any_free;
    logic [SLOT_W-1:0]    free_slot;
    logic [SLOT_W-1:0]    lru_slot;
    logic [SLOT_W-1:0]    min_slot;
    logic [BEN_W-1:0]     min_ben;

    for (genvar g = 0; g < FAST_ROWS; g++) begin : g_match
        assign match[g] = set_i[g].valid && (set_i[g].tag == tag_i);
    end

    always_comb begin
        hit_o      = |match;
        hit_slot_o = '0;
        for (int i = 0; i < FAST_ROWS; i++)
            if (match[i]) hit_slot_o = SLOT_W'(i);
    end

    always_comb begin
        any_free  = 1'b0;
        free_slot = '0;
        for (int i = FAST_ROWS - 1; i >= 0; i--) begin
            if (!set_i[i].valid) begin
                any_free  = 1'b1;
                free_slot = SLOT_W'(i);
            end
        end
        lru_slot = '0;
        for (int i = 0; i < FAST_ROWS; i++)
            if (set_i[i].rank == SLOT_W'(FAST_ROWS - 1)) lru_slot = SLOT_W'(i);
        min_slot = '0;
        min_ben  = set_i[0].benefit;
        for (int i = 1; i < FAST_ROWS; i++) begin
            if (set_i[i].benefit < min_ben) begin
                min_ben  = set_i[i].benefit;
                min_slot = SLOT_W'(i);
            end
        end
        victim_o = any_free ? free_slot : (use_benefit_i ? min_slot : lru_slot);
    end

    // R2: a row is cached in at most one slot of a subarray
    a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
        $countones(match) <= 1);
endmodule

// File: rtl/rc_tag_store.sv
module rc_tag_store import rc_pkg::*; #(
    parameter int NUM_SETS = 4,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  rd_set_i,
    output tag_entry_t        rd_data_o [FAST_ROWS],
    input  logic              upd_en_i,
    input  logic [SET_W-1:0]  upd_set_i,
    input  logic              upd_hit_i,
    input  logic              upd_fill_i,
    input  logic              upd_wr_i,
    input  logic              upd_wait_i,
    input  logic [SLOT_W-1:0] upd_slot_i,
    input  logic [TAG_W-1:0]  upd_tag_i
);
    tag_entry_t        mem [NUM_SETS][FAST_ROWS];
    tag_entry_t        nxt [FAST_ROWS];
    logic [SLOT_W-1:0] old_rank;
    logic [1:0]        inc;
    logic [BEN_W+1:0]  sum;
    logic              sat;
    logic              touch;

    for (genvar g = 0; g < FAST_ROWS; g++) begin : g_rd
        assign rd_data_o[g] = mem[rd_set_i][g];
    end

    always_comb begin
        for (int i = 0; i < FAST_ROWS; i++) nxt[i] = mem[upd_set_i][i];
        touch    = upd_hit_i || upd_fill_i;
        old_rank = mem[upd_set_i][upd_slot_i].rank;
        inc      = 2'd1 + {1'b0, upd_wait_i};
        sum      = {2'b00, mem[upd_set_i][upd_slot_i].benefit} + {{BEN_W{1'b0}}, inc};
        sat      = upd_hit_i && (sum >= {2'b00, BEN_MAX});
        if (touch) begin
            for (int i = 0; i < FAST_ROWS; i++) begin
                if (SLOT_W'(i) == upd_slot_i)  nxt[i].rank = '0;
                else if (nxt[i].rank < old_rank) nxt[i].rank = nxt[i].rank + 1'b1;
            end
        end
        if (upd_fill_i) begin
            nxt[upd_slot_i].valid   = 1'b1;
            nxt[upd_slot_i].dirty   = 1'b0;
            nxt[upd_slot_i].tag     = upd_tag_i;
            nxt[upd_slot_i].benefit = BEN_W'(inc);
        end
        if (upd_hit_i) begin
            nxt[upd_slot_i].dirty   = nxt[upd_slot_i].dirty | upd_wr_i;
            nxt[upd_slot_i].benefit = sat ? BEN_MAX : sum[BEN_W-1:0];
        end
        if (sat) begin
            for (int i = 0; i < FAST_ROWS; i++) nxt[i].benefit = nxt[i].benefit >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int i = 0; i < FAST_ROWS; i++)
                    mem[s][i] <= '{valid: 1'b0, dirty: 1'b0, tag: '0,
                                   rank: SLOT_W'(i), benefit: '0};
        end else if (upd_en_i) begin
            for (int i = 0; i < FAST_ROWS; i++) mem[upd_set_i][i] <= nxt[i];
        end
    end

    // R9: a write hit leaves the entry dirty
    a_r9_write_hit_dirty: assert property (@(posedge clk) disable iff (rst)
        (upd_en_i && upd_hit_i && upd_wr_i) |=> mem[$past(upd_set_i)][$past(upd_slot_i)].dirty);

    // R4: an insertion leaves a valid entry holding the new index
    a_r4_fill_installs: assert property (@(posedge clk) disable iff (rst)
        (upd_en_i && upd_fill_i) |=> (mem[$past(upd_set_i)][$past(upd_slot_i)].valid &&
                                      mem[$past(upd_set_i)][$past(upd_slot_i)].tag == $past(upd_tag_i)));
endmodule

// File: rtl/rc_sequencer.sv
module rc_sequencer import rc_pkg::*; #(
    parameter int MIG_EXTRA = 1,
    parameter int BANK_W    = 1,
    parameter int SUB_W     = 1,
    localparam int CNT_W    = $clog2(MIG_EXTRA + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  plan_t             plan_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [SUB_W-1:0]  sub_i,
    output logic              ready_o,
    output logic              cmd_valid_o,
    output cmd_e              cmd_op_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [SUB_W-1:0]  cmd_sub_o,
    output logic [ROW_W-1:0]  cmd_row_o,
    output logic              cmd_fast_o,
    output logic              resp_valid_o,
    output logic              resp_hit_o,
    output logic              resp_fast_o,
    output logic              resp_fill_o,
    output logic              resp_wb_o
);
    typedef enum logic [3:0] {
        S_IDLE, S_WB_SRC, S_WB_DST, S_WB_WAIT, S_WB_PRE,
        S_MG_SRC, S_MG_DST, S_MG_WAIT, S_ACT, S_ACC, S_PRE
    } seq_state_e;

    seq_state_e        state;
    plan_t             plan_q;
    logic [BANK_W-1:0] bank_q;
    logic [SUB_W-1:0]  sub_q;
    logic [CNT_W-1:0]  cnt;
    logic              wait_done;
    logic [ROW_W-1:0]  access_row;

    assign wait_done = (cnt == CNT_W'(MIG_EXTRA - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            plan_q <= '0;
            bank_q <= '0;
            sub_q  <= '0;
            cnt    <= '0;
        end else begin
            case (state)
                S_IDLE: if (start_i) begin
                    plan_q <= plan_i;
                    bank_q <= bank_i;
                    sub_q  <= sub_i;
                    state  <= plan_i.wb ? S_WB_SRC : (plan_i.fill ? S_MG_SRC : S_ACT);
                end
                S_WB_SRC:  state <= S_WB_DST;
                S_WB_DST:  begin state <= S_WB_WAIT; cnt <= '0; end
                S_WB_WAIT: if (wait_done) state <= S_WB_PRE; else cnt <= cnt + 1'b1;
                S_WB_PRE:  state <= S_MG_SRC;
                S_MG_SRC:  state <= S_MG_DST;
                S_MG_DST:  begin state <= S_MG_WAIT; cnt <= '0; end
                S_MG_WAIT: if (wait_done) state <= S_ACC; else cnt <= cnt + 1'b1;
                S_ACT:     state <= S_ACC;
                S_ACC:     state <= S_PRE;
                S_PRE:     state <= S_IDLE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    assign access_row = (plan_q.hit || plan_q.fill) ? fast_row(plan_q.slot)
                                                    : slow_row(plan_q.new_tag);

    always_comb begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = CMD_ACT;
        cmd_row_o   = access_row;
        cmd_fast_o  = plan_q.hit;
        case (state)
            S_WB_SRC: begin cmd_row_o = fast_row(plan_q.slot);    cmd_fast_o = 1'b0; end
            S_WB_DST: begin cmd_row_o = slow_row(plan_q.old_tag); cmd_fast_o = 1'b0; end
            S_WB_PRE: begin cmd_op_o = CMD_PRE; cmd_row_o = slow_row(plan_q.old_tag); cmd_fast_o = 1'b0; end
            S_MG_SRC: begin cmd_row_o = slow_row(plan_q.new_tag); cmd_fast_o = 1'b0; end
            S_MG_DST: begin cmd_row_o = fast_row(plan_q.slot);    cmd_fast_o = 1'b0; end
            S_ACT:    ;
            S_ACC:    cmd_op_o = plan_q.wr ? CMD_WR : CMD_RD;
            S_PRE:    cmd_op_o = CMD_PRE;
            default: begin
                cmd_valid_o = 1'b0;
                cmd_op_o    = CMD_NOP;
                cmd_row_o   = '0;
                cmd_fast_o  = 1'b0;
            end
        endcase
    end

    assign ready_o      = (state == S_IDLE);
    assign cmd_bank_o   = bank_q;
    assign cmd_sub_o    = sub_q;
    assign resp_valid_o = (state == S_PRE);
    assign resp_hit_o   = plan_q.hit;
    assign resp_fast_o  = plan_q.hit;
    assign resp_fill_o  = plan_q.fill;
    assign resp_wb_o    = plan_q.wb;

    // R11: an accepted request starts with an activate in the next cycle
    a_r11_start_act: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (cmd_valid_o && cmd_op_o == CMD_ACT));

    // R11: the controller is free right after a response
    a_r11_resp_then_ready: assert property (@(posedge clk) disable iff (rst)
        resp_valid_o |=> ready_o);
endmodule

// File: rtl/segrow_cache_ctrl.sv
module segrow_cache_ctrl import rc_pkg::*; #(
    parameter int NUM_BANKS     = 2,
    parameter int SUBS_PER_BANK = 2,
    parameter int MIG_EXTRA     = 1,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int SUB_W    = (SUBS_PER_BANK > 1) ? $clog2(SUBS_PER_BANK) : 1,
    localparam int NUM_SETS = NUM_BANKS * SUBS_PER_BANK,
    localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [SUB_W-1:0]  req_sub,
    input  logic [TAG_W-1:0]  req_row,
    input  logic              req_write,
    input  logic              req_waited,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [SUB_W-1:0]  cmd_sub,
    output logic [ROW_W-1:0]  cmd_row,
    output logic              cmd_fast,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_fast,
    output logic              resp_fill,
    output logic              resp_writeback
);
    policy_e           mode;
    logic [SET_W-1:0]  set_idx;
    tag_entry_t        cur_set [FAST_ROWS];
    logic              hit;
    logic [SLOT_W-1:0] hit_slot;
    logic [SLOT_W-1:0] victim;
    logic              accept;
    plan_t             plan;
    cmd_e              op_w;

    assign mode    = policy_e'(cfg_mode);
    assign set_idx = SET_W'(int'(req_bank) * SUBS_PER_BANK + int'(req_sub));
    assign accept  = req_valid && req_ready;

    rc_tag_store #(.NUM_SETS(NUM_SETS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .rd_set_i   (set_idx),
        .rd_data_o  (cur_set),
        .upd_en_i   (accept),
        .upd_set_i  (set_idx),
        .upd_hit_i  (plan.hit),
        .upd_fill_i (plan.fill),
        .upd_wr_i   (req_write),
        .upd_wait_i (req_waited),
        .upd_slot_i (plan.slot),
        .upd_tag_i  (req_row)
    );

    rc_set_lookup u_lookup (
        .clk           (clk),
        .rst           (rst),
        .set_i         (cur_set),
        .tag_i         (req_row),
        .use_benefit_i (mode == POL_BENEFIT),
        .hit_o         (hit),
        .hit_slot_o    (hit_slot),
        .victim_o      (victim)
    );

    always_comb begin
        plan.hit     = hit;
        plan.fill    = !hit && ((mode == POL_WAITMIN) ? req_waited : 1'b1);
        plan.slot    = hit ? hit_slot : victim;
        plan.wb      = plan.fill && cur_set[victim].valid && cur_set[victim].dirty;
        plan.wr      = req_write;
        plan.old_tag = cur_set[victim].tag;
        plan.new_tag = req_row;
    end

    rc_sequencer #(.MIG_EXTRA(MIG_EXTRA), .BANK_W(BANK_W), .SUB_W(SUB_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (accept),
        .plan_i       (plan),
        .bank_i       (req_bank),
        .sub_i        (req_sub),
        .ready_o      (req_ready),
        .cmd_valid_o  (cmd_valid),
        .cmd_op_o     (op_w),
        .cmd_bank_o   (cmd_bank),
        .cmd_sub_o    (cmd_sub),
        .cmd_row_o    (cmd_row),
        .cmd_fast_o   (cmd_fast),
        .resp_valid_o (resp_valid),
        .resp_hit_o   (resp_hit),
        .resp_fast_o  (resp_fast),
        .resp_fill_o  (resp_fill),
        .resp_wb_o    (resp_writeback)
    );

    assign cmd_op = op_w;

    // R6: in wait-only mode a miss without a wait never starts a migration
    a_r6_no_fill_without_wait: assert property (@(posedge clk) disable iff (rst)
        (accept && mode == POL_WAITMIN && !req_waited && !hit) |=> (cmd_row >= ROW_W'(FAST_ROWS)));
endmodule

// File: tb/test_segrow_cache_ctrl.sv
module test_segrow_cache_ctrl;
    localparam int MIG = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_bank = 1'b0;
    logic       req_sub = 1'b0;
    logic [8:0] req_row = '0;
    logic       req_write = 1'b0;
    logic       req_waited = 1'b0;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic       cmd_bank;
    logic       cmd_sub;
    logic [8:0] cmd_row;
    logic       cmd_fast;
    logic       resp_valid, resp_hit, resp_fast, resp_fill, resp_writeback;

    always #2 clk = ~clk;

    segrow_cache_ctrl #(.NUM_BANKS(2), .SUBS_PER_BANK(2), .MIG_EXTRA(MIG)) i_segrow_cache_ctrl (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_sub(req_sub), .req_row(req_row), .req_write(req_write),
        .req_waited(req_waited), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_sub(cmd_sub), .cmd_row(cmd_row),
        .cmd_fast(cmd_fast), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_fast(resp_fast), .resp_fill(resp_fill), .resp_writeback(resp_writeback)
    );

    int checks = 0;
    int failures = 0;
    int r_hit, r_fast, r_fill, r_wb, r_lat, act0_row, act0_fast, acts, busy_bad;

    // bank, sub, row[8:0], wr, wait, exp_hit, exp_fill, exp_wb
    localparam logic [15:0] VEC [8] = '{
        {1'b0, 1'b0, 9'd10,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b0, 9'd10,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 9'd11,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b0, 9'd11,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 9'd10,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b0, 9'd10,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 9'd479, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b0, 9'd479, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_req(input int bank, input int sub, input int row, input bit wr, input bit wt);
        int n;
        busy_bad = 0; acts = 0; act0_row = -1; act0_fast = -1;
        @(negedge clk);
        if (!req_ready) busy_bad = 1;
        req_bank = bank[0]; req_sub = sub[0]; req_row = 9'(row);
        req_write = wr; req_waited = wt; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (n < 64) begin
            if (cmd_valid && cmd_op == 3'd1) begin
                if (acts == 0) begin act0_row = int'(cmd_row); act0_fast = int'(cmd_fast); end
                acts++;
            end
            if (resp_valid) break;
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            n++;
        end
        r_hit = int'(resp_hit); r_fast = int'(resp_fast);
        r_fill = int'(resp_fill); r_wb = int'(resp_writeback); r_lat = n;
        @(negedge clk);
        if (!req_ready) busy_bad = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 no command after reset", int'(cmd_valid), 0);
        chk("R1 no response after reset", int'(resp_valid), 0);

        // table walk, simple mode
        for (int v = 0; v < 8; v++) begin
            logic [15:0] e;
            int exp_lat;
            e = VEC[v];
            run_req(int'(e[15]), int'(e[14]), int'(e[13:5]), e[4], e[3]);
            exp_lat = e[2] ? 3 : (e[1] ? 4 + MIG : 3);
            chk(e[2] ? "R2 hit flag" : "R1 R5 miss flag", r_hit, int'(e[2]));
            chk("R4 R5 fill flag", r_fill, int'(e[1]));
            chk("R10 writeback flag", r_wb, 0);
            chk(e[2] ? "R2 hit latency" : "R4 fill latency", r_lat, exp_lat);
            chk("R2 fast timing class", r_fast, int'(e[2]));
            if (e[2]) chk("R2 first ACT fast timing", act0_fast, 1);
            else      chk("R3 R4 first ACT slow row", act0_row, 32 + int'(e[13:5]));
            chk("R11 ready handshake", busy_bad, 0);
        end

        // R6 wait-only policy and R3 plain miss
        cfg_mode = 2'd1;
        run_req(1, 0, 5, 0, 0);
        chk("R6 no insert without wait", r_fill, 0);
        chk("R3 plain miss latency", r_lat, 3);
        chk("R3 plain miss row", act0_row, 37);
        chk("R3 plain miss single ACT", acts, 1);
        run_req(1, 0, 5, 0, 0);
        chk("R6 still miss", r_hit, 0);
        run_req(1, 0, 5, 0, 1);
        chk("R6 insert after wait", r_fill, 1);
        run_req(1, 0, 5, 0, 0);
        chk("R6 hit after waited insert", r_hit, 1);
        cfg_mode = 2'd3;
        run_req(1, 0, 6, 0, 0);
        chk("R5 mode 3 inserts", r_fill, 1);

        // R5/R9/R10 LRU and dirty eviction on bank0 sub0
        cfg_mode = 2'd0;
        for (int k = 100; k <= 128; k++) run_req(0, 0, k, 0, 0);
        run_req(0, 0, 200, 0, 0);
        chk("R5 LRU victim clean", r_wb, 0);
        chk("R9 write-miss fill stays clean", r_lat, 4 + MIG);
        chk("R4 migration source row", act0_row, 232);
        chk("R4 two activates", acts, 2);
        run_req(0, 0, 201, 0, 0);
        chk("R10 dirty victim writeback", r_wb, 1);
        chk("R10 writeback latency", r_lat, 7 + 2 * MIG);
        chk("R10 first ACT victim fast row", act0_row, 0);
        chk("R10 four activates", acts, 4);
        run_req(0, 0, 201, 0, 0);
        chk("R4 hit in victim slot", act0_row, 0);
        chk("R2 hit after insert", r_hit, 1);
        run_req(0, 0, 10, 0, 0);
        chk("R5 evicted row misses", r_hit, 0);

        // R7/R8 benefit policy on bank1 sub1
        cfg_mode = 2'd2;
        for (int i = 0; i < 32; i++) run_req(1, 1, 200 + i, 0, 0);
        for (int s = 2; s < 32; s++) repeat (3) run_req(1, 1, 200 + s, 0, 0);
        repeat (2) run_req(1, 1, 200, 0, 0);
        run_req(1, 1, 201, 0, 0);
        repeat (251) run_req(1, 1, 231, 0, 0);
        run_req(1, 1, 300, 0, 0);
        chk("R7 miss inserted", r_fill, 1);
        chk("R9 read-only victim clean", r_wb, 0);
        run_req(1, 1, 201, 0, 0);
        chk("R8 halving ties slot1 with slot0", r_hit, 1);
        run_req(1, 1, 200, 0, 0);
        chk("R7 lowest-index tie evicted", r_hit, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule